// File: doc/BRIEF.md
# Minicomputer Front Panel Controller

This block is the operator console logic for a 12-bit word machine. It reads a bank of twelve value switches, a link switch, a run/halt switch and six pushbuttons, and it owns the panel's view of the program counter, memory address, memory data, accumulator and link registers. Twelve value LEDs show one of four registers, and four indicator LEDs mark which register that is. A link LED and a run LED complete the display.

Every pushbutton passes through a two-flop synchroniser and a counter debouncer. The counter needs the input to hold a new level for `DEBOUNCE_CYCLES` clocks in a row. A clean press then yields exactly one single-cycle action. With the panel halted, the operator can set the program counter, step it, load the accumulator and link, or deposit a word into memory through a one-cycle write port. While the run switch is on, only display selection and the clear button take effect.

Top module: `panel_console`

## Requirements
- R1: After `rst_n` is held low for one clock, `led_value` is 0, `led_src` is 4'b0001 (program counter shown), `led_link` is 0 and `mem_we` is 0.
- R2: Each display-select press advances the shown source in the order program counter, memory address, memory data, accumulator, then back to program counter. `led_src` bit 0, 1, 2 and 3 mark these four sources in that order.
- R3: Exactly one bit of `led_src` is set at any time, and `led_value` equals the register that this bit names.
- R4: With the panel halted, a step press adds one to the program counter modulo 4096, so 7777 octal becomes 0.
- R5: With the panel halted, a load-PC press copies `sw_value` into the program counter.
- R6: With the panel halted, a deposit press copies the program counter into the memory address register and `sw_value` into the memory data register. It also raises `mem_we` for exactly one cycle, with `mem_addr` equal to that program counter value and `mem_wdata` equal to `sw_value`.
- R7: With the panel halted, a load-accumulator press copies `sw_value` into the accumulator and `sw_link` into the link bit. `led_link` always shows the link bit.
- R8: A clear press returns the display to the program counter and zeroes the program counter, accumulator, link, memory address and memory data, whatever the run switch says.
- R9: `led_run` follows `sw_run` two clocks late. While it is on, step, load-PC, deposit and load-accumulator presses change no register and cause no write.
- R10: A button level that holds for fewer than `DEBOUNCE_CYCLES` clocks causes no action.
- R11: A press causes exactly one action, however long it is held and whatever short bounces precede or follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_value | input | 12 | Value switch bank |
| sw_link | input | 1 | Link switch |
| sw_run | input | 1 | Run/halt switch, 1 = run |
| pb_disp | input | 1 | Display-select button, raw |
| pb_step | input | 1 | Step button, raw |
| pb_load_pc | input | 1 | Load program counter button, raw |
| pb_deposit | input | 1 | Deposit button, raw |
| pb_load_ac | input | 1 | Load accumulator button, raw |
| pb_clear | input | 1 | Clear button, raw |
| led_value | output | 12 | Value LEDs |
| led_src | output | 4 | One-hot source indicator LEDs |
| led_link | output | 1 | Link LED |
| led_run | output | 1 | Run LED |
| mem_we | output | 1 | Memory write strobe, one cycle |
| mem_addr | output | 12 | Memory write address |
| mem_wdata | output | 12 | Memory write data |

## Verification
The hardest case to reach from the ports is a button that bounces. A burst of short pulses must not trigger an action, and it must not stretch the press into two actions. The bench drives bursts whose pulses are shorter than the debounce window, both before a long hold and after it, and then reads the program counter on the value LEDs to confirm that it advanced by exactly one. The memory address and memory data registers can only be seen by rotating the display, so the bench keeps track of the expected source and presses display-select until the register it wants is on the LEDs.

// File: rtl/panel_pkg.sv
// Package: shared types for the front panel controller.
// Assumes: four display sources, six pushbuttons in a fixed index order.
package panel_pkg;

    typedef enum logic [1:0] {
        SRC_PC = 2'd0,
        SRC_MA = 2'd1,
        SRC_MD = 2'd2,
        SRC_AC = 2'd3
    } src_e;

    localparam int NUM_SRC   = 4;
    localparam int NUM_BTN   = 6;
    localparam int BTN_DISP  = 0;
    localparam int BTN_STEP  = 1;
    localparam int BTN_LDPC  = 2;
    localparam int BTN_DEP   = 3;
    localparam int BTN_LDAC  = 4;
    localparam int BTN_CLEAR = 5;

endpackage

// File: rtl/panel_sync.sv
// Module: two-flop synchroniser for a bus of slow, level-type panel inputs.
// Assumes: bits are independent switches, so skew between bits is harmless.
module panel_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q;

    // Two register stages so that an asynchronous edge has a cycle to settle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/panel_debounce.sv
// Module: debouncer for one pushbutton, with a press pulse.
// A new level is accepted after STABLE_CYCLES consecutive cycles of
// disagreement with the accepted level. Accepting a high level produces a
// one-cycle pulse.
// Assumes: the raw input is asynchronous; STABLE_CYCLES >= 1.
module panel_debounce #(
    parameter int STABLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic press
);

    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

    logic             level;
    logic             stable_q;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    panel_sync #(.WIDTH(1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (level)
    );

    assign accept = (level != stable_q) && (cnt_q == CNT_LAST);

    // Count cycles of disagreement and restart whenever the input agrees again.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (level == stable_q || accept) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Hold the accepted level and emit one pulse when a press is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
            press    <= 1'b0;
        end else begin
            press <= accept && level;
            if (accept) begin
                stable_q <= level;
            end
        end
    end

endmodule

// File: rtl/panel_regs.sv
// Module: panel-owned register file and the actions that update it.
// Clear has the highest priority. Loads, step and deposit take effect only
// while halted. Display selection works in both modes.
// Assumes: each action input is a single-cycle pulse.
module panel_regs
    import panel_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_q,
    input  logic [WORD_W-1:0] sw_q,
    input  logic              link_sw_q,
    input  logic              act_disp,
    input  logic              act_step,
    input  logic              act_load_pc,
    input  logic              act_deposit,
    input  logic              act_load_ac,
    input  logic              act_clear,
    output src_e              sel_q,
    output logic [WORD_W-1:0] pc_q,
    output logic [WORD_W-1:0] ma_q,
    output logic [WORD_W-1:0] md_q,
    output logic [WORD_W-1:0] ac_q,
    output logic              link_q,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);

    logic halted;
    assign halted = !run_q;

    // Rotate the display source on each select press.
    always_ff @(posedge clk) begin
        if (!rst_n || act_clear) begin
            sel_q <= SRC_PC;
        end else if (act_disp) begin
            sel_q <= src_e'(sel_q + 2'd1);
        end
    end

    // Program counter: a load wins over a step.
    always_ff @(posedge clk) begin
        if (!rst_n || act_clear) begin
            pc_q <= '0;
        end else if (halted && act_load_pc) begin
            pc_q <= sw_q;
        end else if (halted && act_step) begin
            pc_q <= pc_q + 1'b1;
        end
    end

    // Accumulator and link load together from the switches.
    always_ff @(posedge clk) begin
        if (!rst_n || act_clear) begin
            ac_q   <= '0;
            link_q <= 1'b0;
        end else if (halted && act_load_ac) begin
            ac_q   <= sw_q;
            link_q <= link_sw_q;
        end
    end

    // Deposit: capture address and data, issue a one-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n || act_clear) begin
            ma_q      <= '0;
            md_q      <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (halted && act_deposit) begin
            ma_q      <= pc_q;
            md_q      <= sw_q;
            mem_we    <= 1'b1;
            mem_addr  <= pc_q;
            mem_wdata <= sw_q;
        end else begin
            mem_we <= 1'b0;
        end
    end

endmodule

// File: rtl/panel_disp_mux.sv
// Module: routes the selected register to the value LEDs and lights its
// indicator.
// Assumes: the indicator bit index equals the source enum value.
module panel_disp_mux
    import panel_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  src_e                sel,
    input  logic [WORD_W-1:0]   pc,
    input  logic [WORD_W-1:0]   ma,
    input  logic [WORD_W-1:0]   md,
    input  logic [WORD_W-1:0]   ac,
    output logic [WORD_W-1:0]   value,
    output logic [NUM_SRC-1:0]  src_onehot
);

    // Select the register word for the value LEDs.
    always_comb begin
        unique case (sel)
            SRC_PC:  value = pc;
            SRC_MA:  value = ma;
            SRC_MD:  value = md;
            default: value = ac;
        endcase
    end

    // One indicator per source, lit when that source is selected.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_ind
        assign src_onehot[i] = (sel == src_e'(i));
    end

endmodule

// File: rtl/panel_console.sv
// Module: top of the front panel controller.
// Synchronises switches, debounces the buttons, and drives the registers,
// the display and the memory write port.
// Assumes: switches are slow and held steady around a press.
module panel_console
    import panel_pkg::*;
#(
    parameter int WORD_W          = 12,
    parameter int DEBOUNCE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] sw_value,
    input  logic              sw_link,
    input  logic              sw_run,
    input  logic              pb_disp,
    input  logic              pb_step,
    input  logic              pb_load_pc,
    input  logic              pb_deposit,
    input  logic              pb_load_ac,
    input  logic              pb_clear,
    output logic [WORD_W-1:0] led_value,
    output logic [3:0]        led_src,
    output logic              led_link,
    output logic              led_run,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);

    localparam int SYNC_W = WORD_W + 2;

    logic [NUM_BTN-1:0] pb_raw;
    logic [NUM_BTN-1:0] act;
    logic [SYNC_W-1:0]  sw_sync;
    logic [WORD_W-1:0]  sw_q;
    logic               link_sw_q;
    logic               run_q;
    logic               act_disp, act_step, act_load_pc;
    logic               act_deposit, act_load_ac, act_clear;
    src_e               sel_q;
    logic [WORD_W-1:0]  pc_q, ma_q, md_q, ac_q;
    logic               link_q;

    assign pb_raw[BTN_DISP]  = pb_disp;
    assign pb_raw[BTN_STEP]  = pb_step;
    assign pb_raw[BTN_LDPC]  = pb_load_pc;
    assign pb_raw[BTN_DEP]   = pb_deposit;
    assign pb_raw[BTN_LDAC]  = pb_load_ac;
    assign pb_raw[BTN_CLEAR] = pb_clear;

    for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
        panel_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) i_deb (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (pb_raw[b]),
            .press (act[b])
        );
    end

    assign act_disp    = act[BTN_DISP];
    assign act_step    = act[BTN_STEP];
    assign act_load_pc = act[BTN_LDPC];
    assign act_deposit = act[BTN_DEP];
    assign act_load_ac = act[BTN_LDAC];
    assign act_clear   = act[BTN_CLEAR];

    panel_sync #(.WIDTH(SYNC_W)) i_sw_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sw_run, sw_link, sw_value}),
        .q     (sw_sync)
    );

    assign sw_q      = sw_sync[WORD_W-1:0];
    assign link_sw_q = sw_sync[WORD_W];
    assign run_q     = sw_sync[WORD_W+1];

    panel_regs #(.WORD_W(WORD_W)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_q       (run_q),
        .sw_q        (sw_q),
        .link_sw_q   (link_sw_q),
        .act_disp    (act_disp),
        .act_step    (act_step),
        .act_load_pc (act_load_pc),
        .act_deposit (act_deposit),
        .act_load_ac (act_load_ac),
        .act_clear   (act_clear),
        .sel_q       (sel_q),
        .pc_q        (pc_q),
        .ma_q        (ma_q),
        .md_q        (md_q),
        .ac_q        (ac_q),
        .link_q      (link_q),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata)
    );

    panel_disp_mux #(.WORD_W(WORD_W)) i_mux (
        .sel        (sel_q),
        .pc         (pc_q),
        .ma         (ma_q),
        .md         (md_q),
        .ac         (ac_q),
        .value      (led_value),
        .src_onehot (led_src)
    );

    assign led_link = link_q;
    assign led_run  = run_q;

endmodule

// File: rtl/panel_console_chk.sv
// Module: assertion checker for the front panel controller, bound to the top.
// Assumes: it sees the action pulses and the register outputs of the top.
module panel_console_chk #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_q,
    input logic              act_disp,
    input logic              act_step,
    input logic              act_load_pc,
    input logic              act_deposit,
    input logic              act_clear,
    input logic [WORD_W-1:0] pc_q,
    input logic [WORD_W-1:0] sw_q,
    input logic [WORD_W-1:0] led_value,
    input logic [3:0]        led_src,
    input logic              led_link,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata
);

    logic [3:0] src_rot;
    assign src_rot = {led_src[2:0], led_src[3]};

    a_r2_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (act_disp && !act_clear) |=> (led_src == $past(src_rot)));

    a_r3_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(led_src) == 1);

    a_r3_pc_shown: assert property (@(posedge clk) disable iff (!rst_n)
        led_src[0] |-> (led_value == pc_q));

    a_r4_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (act_step && !act_load_pc && !act_clear && !run_q)
        |=> (pc_q == WORD_W'($past(pc_q) + 1'b1)));

    a_r6_deposit_write: assert property (@(posedge clk) disable iff (!rst_n)
        (act_deposit && !act_clear && !run_q)
        |=> (mem_we && mem_addr == $past(pc_q) && mem_wdata == $past(sw_q)));

    a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        act_clear |=> (pc_q == '0 && led_src == 4'b0001 && !led_link));

    a_r9_no_write_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> !mem_we);

    a_r9_pc_frozen_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !act_clear) |=> (pc_q == $past(pc_q)));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        act_step |=> !act_step);

endmodule

bind panel_console panel_console_chk #(.WORD_W(WORD_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_q       (run_q),
    .act_disp    (act_disp),
    .act_step    (act_step),
    .act_load_pc (act_load_pc),
    .act_deposit (act_deposit),
    .act_clear   (act_clear),
    .pc_q        (pc_q),
    .sw_q        (sw_q),
    .led_value   (led_value),
    .led_src     (led_src),
    .led_link    (led_link),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata)
);

// File: tb/test_panel_console.sv
// Bench: scoreboard for memory writes plus direct LED checks.
module test_panel_console;

    localparam int W   = 12;
    localparam int DEB = 8;
    localparam int SETTLE = DEB + 12;

    localparam int P_DISP = 0, P_STEP = 1, P_LDPC = 2;
    localparam int P_DEP  = 3, P_LDAC = 4, P_CLR  = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] sw_value = '0;
    logic         sw_link = 1'b0;
    logic         sw_run = 1'b0;
    logic [5:0]   pb = '0;
    logic [W-1:0] led_value;
    logic [3:0]   led_src;
    logic         led_link, led_run, mem_we;
    logic [W-1:0] mem_addr, mem_wdata;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [2*W-1:0] exp_q[$];
    logic [W-1:0]   exp_pc = '0;
    int             exp_sel = 0;

    always #10 clk = ~clk;

    panel_console #(.WORD_W(W), .DEBOUNCE_CYCLES(DEB)) i_panel_console (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_value   (sw_value),
        .sw_link    (sw_link),
        .sw_run     (sw_run),
        .pb_disp    (pb[P_DISP]),
        .pb_step    (pb[P_STEP]),
        .pb_load_pc (pb[P_LDPC]),
        .pb_deposit (pb[P_DEP]),
        .pb_load_ac (pb[P_LDAC]),
        .pb_clear   (pb[P_CLR]),
        .led_value  (led_value),
        .led_src    (led_src),
        .led_link   (led_link),
        .led_run    (led_run),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
        end
    endtask

    // Monitor: every write must match the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected write", {8'd0, mem_addr, mem_wdata}, 32'd0);
            end else begin
                logic [2*W-1:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_wdata} == e, "R6 write",
                      {8'd0, mem_addr, mem_wdata}, {8'd0, e});
            end
        end
    end

    task automatic press(input int idx, input int hold);
        @(negedge clk);
        pb[idx] = 1'b1;
        repeat (hold) @(negedge clk);
        pb[idx] = 1'b0;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic disp_press();
        press(P_DISP, SETTLE);
        exp_sel = (exp_sel + 1) % 4;
    endtask

    // Driver for deposits: pushes the expected write before pressing.
    task automatic deposit(input logic [W-1:0] v);
        sw_value = v;
        repeat (3) @(negedge clk);
        if (!sw_run) exp_q.push_back({exp_pc, v});
        press(P_DEP, SETTLE);
    endtask

    task automatic see(input logic [W-1:0] v, input string req);
        check(led_src == 4'(1 << exp_sel), {req, " src"}, 32'(led_src), 32'(1 << exp_sel));
        check(led_value == v, {req, " value"}, 32'(led_value), 32'(v));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(led_value == 0, "R1 value", 32'(led_value), 0);
        check(led_src == 4'b0001, "R1 src", 32'(led_src), 1);
        check(!led_link && !mem_we, "R1 link/we", {led_link, mem_we}, 0);

        // R5 load PC
        sw_value = 12'o1234;
        press(P_LDPC, SETTLE); exp_pc = 12'o1234;
        see(exp_pc, "R5 load pc");
        // R4 step
        press(P_STEP, SETTLE); exp_pc++;
        see(exp_pc, "R4 step");
        // R6 deposit, then view MA and MD (R2 rotation, R3 indicator)
        deposit(12'o7070);
        disp_press(); see(12'o1235, "R6 R2 memory address");
        disp_press(); see(12'o7070, "R6 R2 memory data");
        // R7 load accumulator and link
        sw_value = 12'o0777; sw_link = 1'b1;
        press(P_LDAC, SETTLE);
        disp_press(); see(12'o0777, "R7 R3 accumulator");
        check(led_link == 1'b1, "R7 link led", 32'(led_link), 1);
        disp_press(); see(exp_pc, "R2 wrap to pc");

        // R4 modulo wrap
        sw_value = 12'o7777;
        press(P_LDPC, SETTLE); exp_pc = 12'o7777;
        press(P_STEP, SETTLE); exp_pc = 0;
        see(exp_pc, "R4 wrap");

        // R10 short glitch is ignored
        press(P_STEP, DEB / 2);
        see(exp_pc, "R10 glitch");
        // R10 R11 bouncy press then hold: one step only
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); pb[P_STEP] = 1'b1;
            repeat (2) @(negedge clk); pb[P_STEP] = 1'b0;
            repeat (2) @(negedge clk);
        end
        pb[P_STEP] = 1'b1;
        repeat (3 * DEB) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            pb[P_STEP] = 1'b0; repeat (2) @(negedge clk);
            pb[P_STEP] = 1'b1; repeat (2) @(negedge clk);
        end
        pb[P_STEP] = 1'b0;
        repeat (SETTLE) @(negedge clk);
        exp_pc++;
        see(exp_pc, "R11 bounce one step");
        // R11 long hold: one step only
        press(P_STEP, 6 * DEB); exp_pc++;
        see(exp_pc, "R11 long hold");

        // R9 run mode blocks panel loads
        sw_run = 1'b1;
        repeat (4) @(negedge clk);
        check(led_run == 1'b1, "R9 run led", 32'(led_run), 1);
        sw_value = 12'o5555; sw_link = 1'b0;
        press(P_STEP, SETTLE);
        press(P_LDPC, SETTLE);
        deposit(12'o5555);
        press(P_LDAC, SETTLE);
        see(exp_pc, "R9 pc frozen");
        disp_press(); see(12'o1235, "R9 address frozen");
        disp_press(); see(12'o7070, "R9 data frozen");
        disp_press(); see(12'o0777, "R9 accumulator frozen");
        check(led_link == 1'b1, "R9 link frozen", 32'(led_link), 1);
        disp_press(); see(exp_pc, "R9 display works in run");

        // R8 clear from a non-PC view, in run mode
        disp_press(); disp_press();
        press(P_CLR, SETTLE); exp_sel = 0; exp_pc = 0;
        see(0, "R8 clear pc");
        check(led_link == 1'b0, "R8 clear link", 32'(led_link), 0);
        disp_press(); see(0, "R8 clear address");
        disp_press(); see(0, "R8 clear data");
        disp_press(); see(0, "R8 clear accumulator");
        sw_run = 1'b0;
        repeat (4) @(negedge clk);
        check(led_run == 1'b0, "R9 run led off", 32'(led_run), 0);

        check(exp_q.size() == 0, "R6 writes outstanding", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule